// File: doc/BRIEF.md
# Sequenced Byte-Core Multiplier

This block multiplies two 16-bit unsigned numbers into a 32-bit product while owning only one 8x8 multiplier. An accepted start captures both operands. The controller then feeds the core one byte pair per clock: first the high bytes, then the low bytes, then the two mixed pairs. The first two products are written straight into the upper and lower halves of the result. Each mixed product is added into the middle two bytes, and its carry ripples into the top byte.

The same core can also run a single-byte multiply. The caller picks how the two byte operands are read: both unsigned, both signed, or first signed with second unsigned. A byte operation takes one step. It returns the 16-bit product in the low half of the result and refreshes a zero flag and a carry flag taken from that product. Software-free use is assumed: a caller pulses start, watches busy, and picks up the result when done pulses.

Top module: `seq_mul16`

## Requirements
- R1: A wide operation (`wide`=1) produces `result` equal to the full unsigned 32-bit product `a_in * b_in`, including 0xFFFF*0xFFFF, zero operands and 0x00FF*0xFF00.
- R2: If start is sampled high at a rising edge while idle with `wide`=1, busy is high for the next four cycles and `done` is high for exactly the fifth cycle after that edge, with `result` valid from that cycle.
- R3: A start sampled while busy is ignored: the captured operands do not change, no extra done is produced, and the result belongs to the operation already running.
- R4: While idle, `result` and both flags hold their values until an accepted start has begun its steps.
- R5: A byte operation (`wide`=0) multiplies `a_in[7:0]` by `b_in[7:0]` under `mode`: 2'b00 unsigned×unsigned, 2'b01 signed×signed, 2'b10 signed(a)×unsigned(b), 2'b11 treated as unsigned×unsigned. The 16-bit two's complement product appears in `result[15:0]` with `result[31:16]`=0, and `done` is high in the second cycle after the accepting edge.
- R6: After a byte operation, `flag_c` equals bit 15 of the 16-bit product and `flag_z` is 1 exactly when that product is zero.
- R7: A wide operation leaves `flag_z` and `flag_c` unchanged.
- R8: Reset (synchronous, active high) clears `result`, `busy`, `done`, `flag_z` and `flag_c`.
- R9: `done` is a single-cycle pulse and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; accepted only while idle |
| wide | input | 1 | 1: 16x16 unsigned multiply, 0: byte multiply |
| mode | input | 2 | Operand signedness for byte multiply |
| a_in | input | 16 | First operand, captured on accepted start |
| b_in | input | 16 | Second operand, captured on accepted start |
| busy | output | 1 | High while steps are being executed |
| done | output | 1 | One-cycle pulse when result is ready |
| result | output | 32 | Product |
| flag_z | output | 1 | Zero flag of the last byte product |
| flag_c | output | 1 | Bit 15 of the last byte product |

## Verification
The properties take for granted that reset is high at the first clock edge and that `wide`, `mode` and the operands matter only in the cycle start is accepted. They also take for granted that start is judged at a rising edge against the idle state of that same cycle. The stimulus changes every input only on falling edges and holds start for one cycle. It drives a second start only while an operation is running, which is where the ignore rule applies. Operand values are chosen to hit every carry path of the middle-byte additions as well as zero and all-ones corners.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 2 * BYTE_W;
    localparam int FULL_W  = 2 * HALF_W;
    localparam int STEP_W  = 2;

    typedef enum logic [1:0] {
        MODE_UU  = 2'b00,
        MODE_SS  = 2'b01,
        MODE_SU  = 2'b10,
        MODE_ALT = 2'b11
    } sign_mode_e;

    // Order of the wide schedule: the two direct writes come first.
    typedef enum logic [STEP_W-1:0] {
        STEP_HH = 2'd0,
        STEP_LL = 2'd1,
        STEP_LH = 2'd2,
        STEP_HL = 2'd3
    } step_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic x_signed;
        logic y_signed;
    } sign_sel_t;

    function automatic sign_sel_t decode_mode(input logic [1:0] m);
        sign_sel_t s;
        unique case (m)
            MODE_SS: s = '{x_signed: 1'b1, y_signed: 1'b1};
            MODE_SU: s = '{x_signed: 1'b1, y_signed: 1'b0};
            default: s = '{x_signed: 1'b0, y_signed: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/byte_mul_core.sv
module byte_mul_core #(
    parameter int BW = 8
) (
    input  logic [BW-1:0]   x,
    input  logic [BW-1:0]   y,
    input  logic            x_signed,
    input  logic            y_signed,
    output logic [2*BW-1:0] prod,
    output logic            prod_zero,
    output logic            prod_msb
);
    localparam int PW = 2 * BW;

    logic [PW-1:0] x_ext;
    logic [PW-1:0] y_ext;

    // Sign extension to the product width keeps the low bits exact.
    assign x_ext     = {{BW{x_signed & x[BW-1]}}, x};
    assign y_ext     = {{BW{y_signed & y[BW-1]}}, y};
    assign prod      = x_ext * y_ext;
    assign prod_zero = (prod == '0);
    assign prod_msb  = prod[PW-1];

endmodule

// File: rtl/mul_step_ctrl.sv
module mul_step_ctrl
    import mulseq_pkg::*;
#(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          wide,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic          wide_q,
    output logic [SW-1:0] step
);
    localparam logic [SW-1:0] LAST_STEP = {SW{1'b1}};

    ctrl_state_e state;
    logic        last;

    assign busy   = (state == ST_RUN);
    assign accept = start & ~busy;
    assign last   = wide_q ? (step == LAST_STEP) : (step == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            step   <= '0;
            done   <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_RUN;
                        step   <= '0;
                        wide_q <= wide;
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mul_accum.sv
module mul_accum
    import mulseq_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            wide,
    input  logic [1:0]      step,
    input  logic [2*BW-1:0] prod,
    input  logic            prod_zero,
    input  logic            prod_msb,
    output logic [4*BW-1:0] result,
    output logic            flag_z,
    output logic            flag_c
);
    localparam int PW = 2 * BW;
    localparam int RW = 4 * BW;

    logic [BW-1:0] sum1, sum2, sum3;
    logic          cy1, cy2;

    // Middle-byte additions for a cross product, carry rippled to the top byte.
    always_comb begin
        {cy1, sum1} = {1'b0, result[2*BW-1:BW]}   + {1'b0, prod[BW-1:0]};
        {cy2, sum2} = {1'b0, result[3*BW-1:2*BW]} + {1'b0, prod[PW-1:BW]} + {{BW{1'b0}}, cy1};
        sum3        = result[RW-1:3*BW] + {{(BW-1){1'b0}}, cy2};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else if (en) begin
            if (!wide) begin
                result <= {{PW{1'b0}}, prod};
                flag_z <= prod_zero;
                flag_c <= prod_msb;
            end else begin
                unique case (step)
                    STEP_HH: result[RW-1:PW] <= prod;
                    STEP_LL: result[PW-1:0]  <= prod;
                    default: result[RW-1:BW] <= {sum3, sum2, sum1};
                endcase
            end
        end
    end

endmodule

// File: rtl/seq_mul16.sv
module seq_mul16
    import mulseq_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            wide,
    input  logic [1:0]      mode,
    input  logic [2*BW-1:0] a_in,
    input  logic [2*BW-1:0] b_in,
    output logic            busy,
    output logic            done,
    output logic [4*BW-1:0] result,
    output logic            flag_z,
    output logic            flag_c
);
    localparam int PW = 2 * BW;

    logic          accept;
    logic          wide_q;
    logic [1:0]    step;
    logic [PW-1:0] a_q, b_q;
    logic [1:0]    mode_q;
    logic [BW-1:0] op_x, op_y;
    sign_sel_t     sel;
    logic [PW-1:0] prod;
    logic          prod_zero, prod_msb;

    mul_step_ctrl #(.SW(STEP_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .wide   (wide),
        .busy   (busy),
        .done   (done),
        .accept (accept),
        .wide_q (wide_q),
        .step   (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= MODE_UU;
        end else if (accept) begin
            a_q    <= a_in;
            b_q    <= b_in;
            mode_q <= mode;
        end
    end

    // Byte pair routed to the core for the current step.
    always_comb begin
        if (!wide_q) begin
            op_x = a_q[BW-1:0];
            op_y = b_q[BW-1:0];
            sel  = decode_mode(mode_q);
        end else begin
            sel = decode_mode(MODE_UU);
            unique case (step)
                STEP_HH: begin op_x = a_q[PW-1:BW]; op_y = b_q[PW-1:BW]; end
                STEP_LL: begin op_x = a_q[BW-1:0];  op_y = b_q[BW-1:0];  end
                STEP_LH: begin op_x = a_q[BW-1:0];  op_y = b_q[PW-1:BW]; end
                default: begin op_x = a_q[PW-1:BW]; op_y = b_q[BW-1:0];  end
            endcase
        end
    end

    byte_mul_core #(.BW(BW)) u_core (
        .x         (op_x),
        .y         (op_y),
        .x_signed  (sel.x_signed),
        .y_signed  (sel.y_signed),
        .prod      (prod),
        .prod_zero (prod_zero),
        .prod_msb  (prod_msb)
    );

    mul_accum #(.BW(BW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .en        (busy),
        .wide      (wide_q),
        .step      (step),
        .prod      (prod),
        .prod_zero (prod_zero),
        .prod_msb  (prod_msb),
        .result    (result),
        .flag_z    (flag_z),
        .flag_c    (flag_c)
    );

endmodule

// File: rtl/mulseq_checker.sv
module mulseq_checker #(
    parameter int BW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            wide,
    input logic            busy,
    input logic            done,
    input logic            wide_q,
    input logic [2*BW-1:0] a_lat,
    input logic [2*BW-1:0] b_lat,
    input logic [4*BW-1:0] result,
    input logic            flag_z,
    input logic            flag_c
);
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && !done && result == '0 && !flag_z && !flag_c));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r2_wide_latency: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && wide) |-> ##5 done);

    a_r5_byte_latency: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !wide) |-> ##2 done);

    a_r3_operands_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(a_lat) && $stable(b_lat)));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(result) && $stable(flag_z) && $stable(flag_c)));

    a_r7_flags_wide: assert property (@(posedge clk) disable iff (rst)
        (busy && wide_q) |=> ($stable(flag_z) && $stable(flag_c)));

    a_r6_flag_relation: assert property (@(posedge clk) disable iff (rst)
        (done && !wide_q) |-> (flag_z == (result == '0) && flag_c == result[2*BW-1]));

endmodule

bind seq_mul16 mulseq_checker #(.BW(BW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .wide   (wide),
    .busy   (busy),
    .done   (done),
    .wide_q (wide_q),
    .a_lat  (a_q),
    .b_lat  (b_q),
    .result (result),
    .flag_z (flag_z),
    .flag_c (flag_c)
);

// File: tb/seq_mul16_test.sv
`timescale 1ns/1ps
module seq_mul16_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        busy, done, flag_z, flag_c;
    logic [31:0] result;

    typedef struct {
        logic [31:0] res;
        logic        z;
        logic        c;
        logic        is_wide;
        int          t0;
    } exp_t;

    exp_t exp_q[$];
    int   tests = 0;
    int   fails = 0;
    int   cyc   = 0;
    logic exp_z = 1'b0;
    logic exp_c = 1'b0;
    logic [31:0] last_res = '0;
    logic prev_done = 1'b0;
    logic finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seq_mul16 uut (
        .clk(clk), .rst(rst), .start(start), .wide(wide), .mode(mode),
        .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
        .result(result), .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] byte_ref(input logic [7:0] x, input logic [7:0] y,
                                             input logic [1:0] m);
        int ix, iy, p;
        ix = int'(x);
        iy = int'(y);
        if ((m == 2'b01 || m == 2'b10) && x[7]) ix = ix - 256;
        if (m == 2'b01 && y[7]) iy = iy - 256;
        p = ix * iy;
        return p[15:0];
    endfunction

    // Driver: pushes the expectation, pulses start, waits for completion.
    task automatic issue(input logic w, input logic [1:0] m, input logic [15:0] a,
                         input logic [15:0] b, input logic poke_busy);
        exp_t e;
        logic [15:0] p;
        @(negedge clk);
        e.is_wide = w;
        e.t0 = cyc;
        if (w) begin
            e.res = 32'(a) * 32'(b);
        end else begin
            p = byte_ref(a[7:0], b[7:0], m);
            e.res = {16'h0, p};
            exp_z = (p == 16'h0);
            exp_c = p[15];
        end
        e.z = exp_z;
        e.c = exp_c;
        last_res = e.res;
        exp_q.push_back(e);
        wide = w; mode = m; a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        if (poke_busy) begin
            // R3: second start while busy, different operands
            a_in = ~a; b_in = b + 16'h1357; wide = ~w; start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops expectations as done pulses appear.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done && prev_done) chk("R9 done longer than one cycle", 32'(done), 32'(0));
            if (done) begin
                chk("R9 busy low at done", 32'(busy), 32'(0));
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected extra done", 32'(1), 32'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_wide) begin
                        chk("R1 wide product", result, e.res);
                        chk("R2 wide latency", 32'(cyc - e.t0), 32'(5));
                        chk("R7 flags unchanged by wide op", {30'h0, flag_z, flag_c}, {30'h0, e.z, e.c});
                    end else begin
                        chk("R5 byte product", result, e.res);
                        chk("R5 byte latency", 32'(cyc - e.t0), 32'(2));
                        chk("R6 byte flags z,c", {30'h0, flag_z, flag_c}, {30'h0, e.z, e.c});
                    end
                end
            end
            prev_done <= done;
        end
    end

    task automatic finish_run;
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 reset result", result, 32'h0);
        chk("R8 reset busy/done", {30'h0, busy, done}, 32'h0);
        chk("R8 reset flags", {30'h0, flag_z, flag_c}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1 corners
        issue(1'b1, 2'b00, 16'hFFFF, 16'hFFFF, 1'b0);
        issue(1'b1, 2'b00, 16'h0000, 16'h1234, 1'b0);
        issue(1'b1, 2'b00, 16'hBEEF, 16'h0000, 1'b0);
        issue(1'b1, 2'b00, 16'h00FF, 16'hFF00, 1'b0);
        issue(1'b1, 2'b00, 16'h80FF, 16'hFF01, 1'b0);
        issue(1'b1, 2'b00, 16'h0001, 16'h0001, 1'b0);

        // R5/R6 byte modes
        issue(1'b0, 2'b00, 16'h00FF, 16'h00FF, 1'b0);
        issue(1'b0, 2'b01, 16'h00FF, 16'h00FF, 1'b0);
        issue(1'b0, 2'b10, 16'hAAFF, 16'h55FF, 1'b0);
        issue(1'b0, 2'b01, 16'h0080, 16'h0080, 1'b0);
        issue(1'b0, 2'b01, 16'h007F, 16'h0080, 1'b0);
        issue(1'b0, 2'b10, 16'h0080, 16'h0080, 1'b0);
        issue(1'b0, 2'b11, 16'h00F0, 16'h00F0, 1'b0);
        issue(1'b0, 2'b00, 16'h1200, 16'h0034, 1'b0);

        // R7: wide op after a byte op keeps flags (zero flag now set)
        issue(1'b1, 2'b01, 16'hFFFF, 16'h0003, 1'b0);
        issue(1'b0, 2'b10, 16'h00FF, 16'h0001, 1'b0);
        issue(1'b1, 2'b00, 16'h1234, 16'h5678, 1'b0);

        // R3: start while busy, both kinds of op
        issue(1'b1, 2'b00, 16'hA5A5, 16'h5A5A, 1'b1);
        issue(1'b0, 2'b01, 16'h00C3, 16'h0071, 1'b1);

        // R4: idle hold
        repeat (8) @(negedge clk);
        chk("R4 result held while idle", result, last_res);
        chk("R4 flags held while idle", {30'h0, flag_z, flag_c}, {30'h0, exp_z, exp_c});

        // R1 random operands
        for (int i = 0; i < 40; i++) begin
            issue(1'b1, 2'b00, 16'($urandom), 16'($urandom), 1'b0);
        end
        for (int i = 0; i < 20; i++) begin
            issue(1'b0, 2'($urandom), 16'($urandom), 16'($urandom), 1'b0);
        end

        repeat (4) @(negedge clk);
        chk("R3 no pending expectations", 32'(exp_q.size()), 32'(0));
        finish_run();
    end

endmodule